// File: doc/BRIEF.md
# Multi-Format Audio Serial Slave Port

This block connects a stereo PCM serial link, driven by an external host, to parallel sample words inside the chip. The host supplies the bit clock and the word-select clock. The port receives left and right samples from the serial data input and presents them as a pair of parallel words with a one-cycle valid strobe. At the same time it serializes a pair of parallel transmit words onto the serial data output.

Three framing formats can be selected at runtime: I2S, left-justified and right-justified. All three send the most significant bit first. The sample width can be set to 16, 20 or 24 bits. Word select marks the start of every half-frame, so the sample rate is whatever the host clocks, from 8 kHz up to 96 kHz, and the serial logic has no rate setting.

All serial pins are brought into the system clock domain through a synchronizer, and edges are detected there. The system clock must run at least eight times faster than the bit clock. The host changes word select and data on the falling edge of the bit clock. Parallel words are left-aligned in a 24-bit field.

Top module: `aud_serial_slave`

## Requirements
- R1: After reset, rx_valid is 0, rx_left and rx_right are 0, and sd_out is 0.
- R2: With fmt_sel=0 (I2S), word select low is the left channel, and the sample MSB is on the second rising bit-clock edge after a word-select change.
- R3: With fmt_sel=1 (left-justified), word select high is the left channel, and the MSB is on the first rising bit-clock edge after a word-select change.
- R4: With fmt_sel=2 (right-justified), word select high is the left channel, the half-frame is 32 bit clocks, and the LSB is on the last rising edge before the next word-select change.
- R5: width_sel=0/1/2 selects 16/20/24 bits. The received word occupies bits 23 downward, and the unused low bits read as zero.
- R6: Data input bits that fall outside the sample window of a half-frame have no effect on the received words.
- R7: rx_valid pulses for exactly one system-clock cycle once per frame, when the right sample is complete after a left sample. rx_left and rx_right change only in that cycle.
- R8: Transmit data changes after bit-clock falling edges. It carries tx_left in the left half-frame and tx_right in the right half-frame, MSB first, in the same bit positions as receive. sd_out is 0 outside the window.
- R9: tx_left and tx_right are captured at the start of each left half-frame. Changes to them later in that frame do not alter the bits sent in that frame.
- R10: Half-frames of any length that holds the window, and any bit-clock rate, are accepted with no change of configuration.
- R11: Until the first word-select change after reset, no sample is captured and sd_out stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 treated as I2S |
| width_sel | input | 2 | Sample width: 0 16 bits, 1 20 bits, other 24 bits |
| sck_in | input | 1 | Bit clock from host |
| ws_in | input | 1 | Word select from host |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| tx_left | input | 24 | Left transmit sample, left-aligned |
| tx_right | input | 24 | Right transmit sample, left-aligned |
| rx_left | output | 24 | Left received sample, left-aligned |
| rx_right | output | 24 | Right received sample, left-aligned |
| rx_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
The assertions are checked on every cycle. They cover:
- the quiet outputs right after reset;
- the one-cycle width of the valid strobe;
- received words holding still between strobes;
- zeroed low bits for the 16- and 20-bit widths.

Only the bench's host scenarios can show the rest:
- bit placement for each framing format and width;
- rejection of garbage bits outside the window;
- transmit words being taken at the frame start;
- half-frame lengths and bit-clock rates that vary between scenarios.

// File: rtl/aud_pkg.sv
// Shared constants, types and decode helpers for the audio serial slave port.
package aud_pkg;

    localparam int SAMPLE_W = 24;
    localparam int SLOT_W   = 32;
    localparam int POS_W    = $clog2(SLOT_W) + 1;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_RSVD  = 2'd3
    } fmt_e;

    // Number of sample bits selected by the width code.
    function automatic pos_t word_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return pos_t'(16);
            2'd1:    return pos_t'(20);
            default: return pos_t'(24);
        endcase
    endfunction

    // Bit-clock slots between the half-frame start and the sample MSB.
    function automatic pos_t lead_gap(input fmt_e f, input pos_t w);
        case (f)
            FMT_LEFT:  return pos_t'(0);
            FMT_RIGHT: return pos_t'(SLOT_W) - w;
            default:   return pos_t'(1);
        endcase
    endfunction

    // True when the word-select level denotes the left channel.
    function automatic logic chan_is_left(input fmt_e f, input logic ws);
        if (f == FMT_LEFT || f == FMT_RIGHT) return ws;
        return ~ws;
    endfunction

endpackage

// File: rtl/aud_edge_sync.sv
// Multi-stage synchronizer for the host serial pins, with edge detection
// on bit 0 (the bit clock). All bits share one chain, so data sampled
// together with a detected edge has the same latency as that edge.
// Assumes STAGES >= 1 and a system clock much faster than bit 0 toggles.
module aud_edge_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out,
    output logic             rise0,
    output logic             fall0
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic                         prev0_q;

    // Shift the asynchronous pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

    // Remember the last synchronized bit clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev0_q <= 1'b0;
        else        prev0_q <= sync_out[0];
    end

    assign rise0 = sync_out[0] & ~prev0_q;
    assign fall0 = ~sync_out[0] & prev0_q;

endmodule

// File: rtl/aud_frame_track.sv
// Tracks the half-frame position from word-select changes seen at bit-clock
// rising edges. It gives the slot index of the current bit-clock period
// (used at a rising edge) or of the next one (used at a falling edge),
// and which channel that slot belongs to.
// Assumes word select changes only with bit-clock falling edges.
module aud_frame_track
    import aud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  fmt_e fmt,
    input  logic ws_s,
    input  logic rise,
    output pos_t slot_pos,
    output logic slot_left,
    output logic slot_ok
);

    localparam pos_t POS_MAX = {POS_W{1'b1}};

    logic primed_q;
    logic synced_q;
    logic ws_last_q;
    pos_t pos_q;
    logic ws_moved;

    assign ws_moved  = (ws_s != ws_last_q);
    assign slot_pos  = ws_moved ? '0 : ((pos_q == POS_MAX) ? POS_MAX : pos_q + 1'b1);
    assign slot_left = chan_is_left(fmt, ws_s);
    assign slot_ok   = primed_q && (synced_q || ws_moved);

    // Advance or restart the slot counter at each bit-clock rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q  <= 1'b0;
            synced_q  <= 1'b0;
            ws_last_q <= 1'b0;
            pos_q     <= '0;
        end else if (rise) begin
            ws_last_q <= ws_s;
            if (!primed_q) begin
                primed_q <= 1'b1;
                pos_q    <= POS_MAX;
            end else begin
                pos_q <= slot_pos;
                if (ws_moved) synced_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/aud_rx_deser.sv
// Receive deserializer. It samples serial data at bit-clock rising edges
// within the sample window of each half-frame and assembles left-aligned
// words. When a right word completes after a left one, it publishes the
// pair with a one-cycle strobe.
// Assumes the width and format are stable while a frame is in progress.
module aud_rx_deser
    import aud_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  fmt_e                fmt,
    input  logic [1:0]          width_sel,
    input  logic                rise,
    input  logic                sd_s,
    input  pos_t                slot_pos,
    input  logic                slot_left,
    input  logic                slot_ok,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);

    pos_t                w_bits;
    pos_t                gap;
    logic                in_win;
    pos_t                rel;
    pos_t                shamt;
    logic                last_bit;
    logic [SAMPLE_W-1:0] acc_q;
    logic [SAMPLE_W-1:0] acc_next;
    logic [SAMPLE_W-1:0] left_hold_q;
    logic                have_left_q;

    assign w_bits   = word_bits(width_sel);
    assign gap      = lead_gap(fmt, w_bits);
    assign in_win   = (slot_pos >= gap) && (slot_pos < gap + w_bits);
    assign rel      = slot_pos - gap;
    assign shamt    = pos_t'(SAMPLE_W - 1) - rel;
    assign last_bit = (rel == w_bits - 1'b1);

    // Merge the incoming bit into the word, restarting at the MSB slot.
    always_comb begin
        acc_next = (rel == '0) ? '0 : acc_q;
        acc_next = acc_next | (SAMPLE_W'(sd_s) << shamt);
    end

    // Capture bits and publish completed stereo pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q       <= '0;
            left_hold_q <= '0;
            have_left_q <= 1'b0;
            rx_left     <= '0;
            rx_right    <= '0;
            rx_valid    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rise && slot_ok && in_win) begin
                acc_q <= acc_next;
                if (last_bit) begin
                    if (slot_left) begin
                        left_hold_q <= acc_next;
                        have_left_q <= 1'b1;
                    end else if (have_left_q) begin
                        rx_left     <= left_hold_q;
                        rx_right    <= acc_next;
                        rx_valid    <= 1'b1;
                        have_left_q <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/aud_tx_ser.sv
// Transmit serializer. At each bit-clock falling edge it drives the bit
// belonging to the next slot. It takes both channel words at the start of
// the left half-frame and sends zero outside the sample window.
// Assumes word select has settled by the time the falling edge is seen.
module aud_tx_ser
    import aud_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  fmt_e                fmt,
    input  logic [1:0]          width_sel,
    input  logic                fall,
    input  pos_t                slot_pos,
    input  logic                slot_left,
    input  logic                slot_ok,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                sd_out
);

    pos_t                w_bits;
    pos_t                gap;
    logic                in_win;
    pos_t                shamt;
    logic                frame_start;
    logic [SAMPLE_W-1:0] word;
    logic [SAMPLE_W-1:0] shifted;
    logic [SAMPLE_W-1:0] hold_l_q;
    logic [SAMPLE_W-1:0] hold_r_q;

    assign w_bits      = word_bits(width_sel);
    assign gap         = lead_gap(fmt, w_bits);
    assign in_win      = (slot_pos >= gap) && (slot_pos < gap + w_bits);
    assign shamt       = pos_t'(SAMPLE_W - 1) - (slot_pos - gap);
    assign frame_start = slot_ok && slot_left && (slot_pos == '0);

    // Pick the word for the coming slot, bypassing the hold at frame start.
    always_comb begin
        if (frame_start)    word = tx_left;
        else if (slot_left) word = hold_l_q;
        else                word = hold_r_q;
        shifted = word >> shamt;
    end

    // Latch frame words and drive the output bit at bit-clock falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l_q <= '0;
            hold_r_q <= '0;
            sd_out   <= 1'b0;
        end else if (fall) begin
            if (frame_start) begin
                hold_l_q <= tx_left;
                hold_r_q <= tx_right;
            end
            sd_out <= slot_ok && in_win && shifted[0];
        end
    end

endmodule

// File: rtl/aud_serial_slave.sv
// Top of the slave-mode stereo serial audio port. It synchronizes the
// host pins, tracks half-frame slots, deserializes receive samples and
// serializes transmit samples. Framing and width come from fmt_sel and
// width_sel, which are expected to change only while the link is idle or
// in reset.
module aud_serial_slave
    import aud_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          width_sel,
    input  logic                sck_in,
    input  logic                ws_in,
    input  logic                sd_in,
    output logic                sd_out,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid
);

    localparam int PIN_W = 3;

    fmt_e             fmt;
    logic [PIN_W-1:0] pins_s;
    logic             sck_rise;
    logic             sck_fall;
    pos_t             slot_pos;
    logic             slot_left;
    logic             slot_ok;

    assign fmt = fmt_e'(fmt_sel);

    aud_edge_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sd_in, ws_in, sck_in}),
        .sync_out (pins_s),
        .rise0    (sck_rise),
        .fall0    (sck_fall)
    );

    aud_frame_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt       (fmt),
        .ws_s      (pins_s[1]),
        .rise      (sck_rise),
        .slot_pos  (slot_pos),
        .slot_left (slot_left),
        .slot_ok   (slot_ok)
    );

    aud_rx_deser u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt       (fmt),
        .width_sel (width_sel),
        .rise      (sck_rise),
        .sd_s      (pins_s[2]),
        .slot_pos  (slot_pos),
        .slot_left (slot_left),
        .slot_ok   (slot_ok),
        .rx_left   (rx_left),
        .rx_right  (rx_right),
        .rx_valid  (rx_valid)
    );

    aud_tx_ser u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt       (fmt),
        .width_sel (width_sel),
        .fall      (sck_fall),
        .slot_pos  (slot_pos),
        .slot_left (slot_left),
        .slot_ok   (slot_ok),
        .tx_left   (tx_left),
        .tx_right  (tx_right),
        .sd_out    (sd_out)
    );

endmodule

// File: rtl/aud_serial_slave_chk.sv
// Port-level checker for the audio serial slave port, bound to the top.
module aud_serial_slave_chk
    import aud_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          fmt_sel,
    input logic [1:0]          width_sel,
    input logic                sck_in,
    input logic                ws_in,
    input logic                sd_in,
    input logic                sd_out,
    input logic [SAMPLE_W-1:0] tx_left,
    input logic [SAMPLE_W-1:0] tx_right,
    input logic [SAMPLE_W-1:0] rx_left,
    input logic [SAMPLE_W-1:0] rx_right,
    input logic                rx_valid
);

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!rx_valid && !sd_out)); // R1

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7

    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_left) && $stable(rx_right))); // R7

    AST_LOW_ZERO_16: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && width_sel == 2'd0) |-> (rx_left[7:0] == '0 && rx_right[7:0] == '0)); // R5

    AST_LOW_ZERO_20: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && width_sel == 2'd1) |-> (rx_left[3:0] == '0 && rx_right[3:0] == '0)); // R5

endmodule

bind aud_serial_slave aud_serial_slave_chk u_chk (.*);

// File: tb/aud_serial_slave_tb.sv
// Bench: emulates the host driving the serial link and checks both directions.
module aud_serial_slave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [1:0]  width_sel = 2'd0;
    logic        sck_in = 1'b1;
    logic        ws_in = 1'b1;
    logic        sd_in = 1'b0;
    logic        sd_out;
    logic [23:0] tx_left = '0;
    logic [23:0] tx_right = '0;
    logic [23:0] rx_left;
    logic [23:0] rx_right;
    logic        rx_valid;

    int checks = 0;
    int failures = 0;
    int hp = 5;
    int cur_fmt = 0;
    int cur_w = 16;
    int rx_count = 0;
    int exp_n = 0;
    logic [23:0] exp_l [0:7];
    logic [23:0] exp_r [0:7];
    string cur_tag = "";

    always #5 clk = ~clk;

    aud_serial_slave u_dut (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic int gap_of(input int f, input int w);
        if (f == 1) return 0;
        if (f == 2) return 32 - w;
        return 1;
    endfunction

    function automatic logic [23:0] trim(input logic [23:0] x, input int w);
        return x & ({24{1'b1}} << (24 - w));
    endfunction

    function automatic logic bit_at(input logic [23:0] word, input int f, input int w, input int p);
        int j;
        j = p - gap_of(f, w);
        if (j >= 0 && j < w) return word[23 - j];
        return 1'b0;
    endfunction

    function automatic logic ws_lvl(input int f, input bit left);
        return (f == 0) ? ~left : left;
    endfunction

    // Receive monitor: compare each published pair with the expected frame.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_count < exp_n)
                check(rx_left == exp_l[rx_count] && rx_right == exp_r[rx_count],
                      {cur_tag, " R5 R6 rx pair"}, {16'h0, rx_left, rx_right},
                      {16'h0, exp_l[rx_count], exp_r[rx_count]});
            else
                check(1'b0, "R7 extra rx_valid", 64'(rx_count), 64'(exp_n));
            rx_count++;
        end
    end

    // One half-frame as host: drive data, sample sd_out before each rise.
    task automatic run_half(input bit left, input logic [23:0] rxw, input logic [23:0] txw,
                            input int n, input bit tx_on, input bit swap_tx, input string tag);
        logic [31:0] got = '0;
        logic [31:0] exp = '0;
        for (int p = 0; p < n; p++) begin
            int j;
            sck_in = 1'b0;
            ws_in  = ws_lvl(cur_fmt, left);
            j = p - gap_of(cur_fmt, cur_w);
            sd_in  = (j >= 0 && j < cur_w) ? rxw[23 - j] : 1'($urandom);
            if (swap_tx && p == 3) begin
                tx_left  = $urandom;
                tx_right = $urandom;
            end
            repeat (hp) @(negedge clk);
            got[p] = sd_out;
            exp[p] = tx_on ? bit_at(txw, cur_fmt, cur_w, p) : 1'b0;
            sck_in = 1'b1;
            repeat (hp) @(negedge clk);
        end
        check(got == exp, tag, 64'(got), 64'(exp));
    endtask

    task automatic run_scn(input int f, input int wsel, input int hpv, input int n,
                           input int nfr, input string tag);
        fmt_sel   = 2'(f);
        width_sel = 2'(wsel);
        cur_fmt   = f;
        cur_w     = (wsel == 0) ? 16 : (wsel == 1) ? 20 : 24;
        hp        = hpv;
        cur_tag   = tag;
        rst_n     = 1'b0;
        sck_in    = 1'b1;
        ws_in     = ws_lvl(f, 1'b0);
        repeat (3) @(negedge clk);
        rst_n    = 1'b1;
        rx_count = 0;
        exp_n    = nfr;
        repeat (3) @(negedge clk);
        // R11: right-level preamble before any word-select change
        run_half(1'b0, 24'($urandom), '0, n, 1'b0, 1'b0, {tag, " R11 preamble tx"});
        for (int fr = 0; fr < nfr; fr++) begin
            logic [23:0] l_w, r_w, tl, tr;
            l_w = trim(24'($urandom), cur_w);
            r_w = trim(24'($urandom), cur_w);
            tl  = 24'($urandom);
            tr  = 24'($urandom);
            exp_l[fr] = l_w;
            exp_r[fr] = r_w;
            tx_left  = tl;
            tx_right = tr;
            // R8 R9: words swapped at slot 3 must not leak into this frame
            run_half(1'b1, l_w, tl, n, 1'b1, 1'b1, {tag, " R8 R9 tx left"});
            run_half(1'b0, r_w, tr, n, 1'b1, 1'b0, {tag, " R8 R9 tx right"});
        end
        repeat (20) @(negedge clk);
        check(rx_count == nfr, {tag, " R7 R10 frame count"}, 64'(rx_count), 64'(nfr));
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rx_valid && rx_left == '0 && rx_right == '0 && !sd_out, "R1 reset state",
              {15'h0, rx_valid, rx_left, rx_right}, 64'h0);
        run_scn(0, 0, 5, 32, 3, "R2 i2s16");
        run_scn(0, 1, 6, 32, 3, "R2 i2s20");
        run_scn(0, 2, 4, 25, 3, "R2 R10 i2s24 short");
        run_scn(1, 0, 7, 32, 3, "R3 lj16");
        run_scn(1, 1, 5, 32, 3, "R3 lj20");
        run_scn(1, 2, 4, 24, 3, "R3 R10 lj24 short");
        run_scn(2, 0, 5, 32, 3, "R4 rj16");
        run_scn(2, 1, 8, 32, 3, "R4 rj20");
        run_scn(2, 2, 4, 32, 3, "R4 rj24");
        for (int k = 0; k < 4; k++) begin
            int f, wsel, w, n, lead;
            f    = int'($urandom % 3);
            wsel = int'($urandom % 3);
            w    = (wsel == 0) ? 16 : (wsel == 1) ? 20 : 24;
            lead = (f == 0) ? 1 : 0;
            n    = (f == 2) ? 32 : w + lead + int'($urandom % (32 - w - lead + 1));
            run_scn(f, wsel, 4 + int'($urandom % 5), n, 3, "R10 random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule